// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small eight-bit processor core. Each clock it can take the outcome of one arithmetic/logic step (the result byte, its carry, the carry out of the low nibble and a signed-overflow indication), together with a handful of control strobes. From these it works out the new sign, zero, carry, overflow, half-carry, break and interrupt-enable flags. It presents them both as one packed byte and as separate wires.

The ALU step is tagged with a two-bit class. The class decides which flags that step may touch. Control strobes come from the instruction sequencer or the interrupt logic. A strobe takes precedence over the ALU step for any flag both want to change. A full-byte write, used when the status word is restored from the stack, overrides everything in the cycle it is given.

All state is held in one register with a synchronous active-high reset. Outputs change one clock after the inputs that cause them.

Top module: `stat_flag_unit`

## Requirements
- R1: The packed byte holds, from bit 7 down to bit 0: sign N, overflow V, a spare bit, break B, half carry H, interrupt enable I, zero Z, carry C. The spare bit 5 reads 0 at all times, even after a write of 1 to it. Each single-flag output equals its bit in the packed byte.
- R2: A clock edge with `rst` high puts the packed byte at 0x00.
- R3: When `res_valid` is high, Z is loaded with (result == 0) and N with result bit 7, for every class.
- R4: Class codes are 2'b00 move, 2'b01 arithmetic, 2'b10 shift/rotate and 2'b11 (treated as move). Move changes only N and Z. Arithmetic also loads C from `res_carry`, V from `res_ovf` and H from `res_half`. Shift/rotate also loads C, and leaves V and H as they were.
- R5: `cmd_clrv` clears V and H together, in preference to a same-cycle ALU result. No other strobe sets or clears H.
- R6: `cmd_bit` loads N from `bit_mem` bit 7 and V from `bit_mem` bit 6. This takes precedence over the ALU result for those two flags, while Z and C still follow the result. `cmd_clrv` in the same cycle wins for V.
- R7: `cmd_brk` sets B. Only reset or a full-byte write clears it.
- R8: `cmd_ei` sets I, while `cmd_di` and `irq_ack` clear it. Both `irq_ack` and `cmd_di` win over a same-cycle `cmd_ei`.
- R9: `wr_en` loads `wr_data`, with bit 5 forced to 0, and overrides every other input in that cycle.
- R10: With no strobe and no `res_valid`, the packed byte holds its value whatever the data inputs carry. Every change is visible one clock after the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | ALU result is presented this cycle |
| res_class | input | 2 | ALU step class (R4 encoding) |
| res_data | input | DW | ALU result byte |
| res_carry | input | 1 | Carry or borrow out of the ALU |
| res_half | input | 1 | Carry out of bit 3 (no borrow from bit 4 on subtract) |
| res_ovf | input | 1 | Signed overflow of the ALU step |
| cmd_ei | input | 1 | Enable interrupts |
| cmd_di | input | 1 | Disable interrupts |
| cmd_clrv | input | 1 | Clear overflow and half carry |
| cmd_bit | input | 1 | Bit test: copy memory bits 7 and 6 |
| bit_mem | input | DW | Memory operand of the bit test |
| cmd_brk | input | 1 | Software break taken |
| irq_ack | input | 1 | Interrupt accepted |
| wr_en | input | 1 | Load the whole status byte |
| wr_data | input | 8 | Status byte to load |
| psw | output | 8 | Packed status byte |
| flag_n | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| flag_b | output | 1 | Break flag |
| flag_h | output | 1 | Half-carry flag |
| flag_i | output | 1 | Interrupt enable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench aims at same-cycle collisions:
- An interrupt acceptance together with an enable strobe. A design that let the enable win would leave I high on entry to a handler.
- A clear-overflow strobe next to an arithmetic result that reports overflow and half carry. A design that ranked the result first would leave V or H set.
- A bit test next to an ALU result. A wrong order would take N or V from the result, or would disturb Z and C.

Further cases:
- A full write of 0xFF, which exposes a spare bit that is not tied low.
- A write that coincides with every other strobe, which shows whether the write has the last word.
- Move and shift steps, which must not spill into C, V or H.
- Idle cycles with live data inputs, which catch a flag that updates without a valid strobe.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  localparam int PSW_W = 8;

  // Bit positions inside the packed status byte; neighbours decode these.
  localparam int POS_C     = 0;
  localparam int POS_Z     = 1;
  localparam int POS_I     = 2;
  localparam int POS_H     = 3;
  localparam int POS_B     = 4;
  localparam int POS_SPARE = 5;
  localparam int POS_V     = 6;
  localparam int POS_N     = 7;

  localparam logic [PSW_W-1:0] SPARE_MASK = PSW_W'(1) << POS_SPARE;

  typedef enum logic [1:0] {
    CLS_MOVE  = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_SHIFT = 2'b10,
    CLS_ALT   = 2'b11
  } alu_class_e;

  // Per-bit request: en marks the bits a source wants to load, val their values.
  typedef struct packed {
    logic [PSW_W-1:0] en;
    logic [PSW_W-1:0] val;
  } flag_upd_t;

endpackage

// File: rtl/sfu_result_eval.sv
module sfu_result_eval
  import sfu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          res_valid,
  input  logic [1:0]    res_class,
  input  logic [DW-1:0] res_data,
  input  logic          res_carry,
  input  logic          res_half,
  input  logic          res_ovf,
  output flag_upd_t     upd
);

  logic is_zero;
  assign is_zero = (res_data == '0);

  always_comb begin
    upd = '0;
    if (res_valid) begin
      upd.en[POS_N]  = 1'b1;
      upd.val[POS_N] = res_data[DW-1];
      upd.en[POS_Z]  = 1'b1;
      upd.val[POS_Z] = is_zero;
      unique case (alu_class_e'(res_class))
        CLS_ARITH: begin
          upd.en[POS_C]  = 1'b1;
          upd.val[POS_C] = res_carry;
          upd.en[POS_V]  = 1'b1;
          upd.val[POS_V] = res_ovf;
          upd.en[POS_H]  = 1'b1;
          upd.val[POS_H] = res_half;
        end
        CLS_SHIFT: begin
          upd.en[POS_C]  = 1'b1;
          upd.val[POS_C] = res_carry;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfu_cmd_eval.sv
module sfu_cmd_eval
  import sfu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cmd_ei,
  input  logic          cmd_di,
  input  logic          cmd_clrv,
  input  logic          cmd_bit,
  input  logic [DW-1:0] bit_mem,
  input  logic          cmd_brk,
  input  logic          irq_ack,
  output flag_upd_t     upd
);

  always_comb begin
    upd = '0;
    // Interrupt enable: acceptance and disable beat enable.
    if (irq_ack || cmd_di) begin
      upd.en[POS_I]  = 1'b1;
      upd.val[POS_I] = 1'b0;
    end else if (cmd_ei) begin
      upd.en[POS_I]  = 1'b1;
      upd.val[POS_I] = 1'b1;
    end
    // Overflow and half carry: the clear strobe beats the bit-test copy.
    if (cmd_clrv) begin
      upd.en[POS_V]  = 1'b1;
      upd.val[POS_V] = 1'b0;
      upd.en[POS_H]  = 1'b1;
      upd.val[POS_H] = 1'b0;
    end else if (cmd_bit) begin
      upd.en[POS_V]  = 1'b1;
      upd.val[POS_V] = bit_mem[DW-2];
    end
    if (cmd_bit) begin
      upd.en[POS_N]  = 1'b1;
      upd.val[POS_N] = bit_mem[DW-1];
    end
    if (cmd_brk) begin
      upd.en[POS_B]  = 1'b1;
      upd.val[POS_B] = 1'b1;
    end
  end

endmodule

// File: rtl/sfu_flag_bank.sv
module sfu_flag_bank
  import sfu_pkg::*;
#(
  parameter int               W         = PSW_W,
  parameter logic [W-1:0]     RESET_VAL = '0,
  parameter logic [W-1:0]     TIE_LOW   = SPARE_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  flag_upd_t    cmd_upd,
  input  flag_upd_t    res_upd,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (TIE_LOW[i]) begin : g_tied
      assign q[i] = 1'b0 & (wr_data[i] | cmd_upd.en[i] | cmd_upd.val[i]
                            | res_upd.en[i] | res_upd.val[i]);
    end else begin : g_reg
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                 bit_q <= RESET_VAL[i];
        else if (wr_en)          bit_q <= wr_data[i];
        else if (cmd_upd.en[i])  bit_q <= cmd_upd.val[i];
        else if (res_upd.en[i])  bit_q <= res_upd.val[i];
      end
      assign q[i] = bit_q;
    end
  end

endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import sfu_pkg::*;
#(
  parameter int               DW        = 8,
  parameter logic [PSW_W-1:0] RESET_VAL = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [1:0]       res_class,
  input  logic [DW-1:0]    res_data,
  input  logic             res_carry,
  input  logic             res_half,
  input  logic             res_ovf,
  input  logic             cmd_ei,
  input  logic             cmd_di,
  input  logic             cmd_clrv,
  input  logic             cmd_bit,
  input  logic [DW-1:0]    bit_mem,
  input  logic             cmd_brk,
  input  logic             irq_ack,
  input  logic             wr_en,
  input  logic [PSW_W-1:0] wr_data,
  output logic [PSW_W-1:0] psw,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_b,
  output logic             flag_h,
  output logic             flag_i,
  output logic             flag_z,
  output logic             flag_c
);

  flag_upd_t res_upd;
  flag_upd_t cmd_upd;

  sfu_result_eval #(.DW(DW)) u_res (
    .res_valid (res_valid),
    .res_class (res_class),
    .res_data  (res_data),
    .res_carry (res_carry),
    .res_half  (res_half),
    .res_ovf   (res_ovf),
    .upd       (res_upd)
  );

  sfu_cmd_eval #(.DW(DW)) u_cmd (
    .cmd_ei   (cmd_ei),
    .cmd_di   (cmd_di),
    .cmd_clrv (cmd_clrv),
    .cmd_bit  (cmd_bit),
    .bit_mem  (bit_mem),
    .cmd_brk  (cmd_brk),
    .irq_ack  (irq_ack),
    .upd      (cmd_upd)
  );

  sfu_flag_bank #(
    .W         (PSW_W),
    .RESET_VAL (RESET_VAL & ~SPARE_MASK),
    .TIE_LOW   (SPARE_MASK)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd_upd (cmd_upd),
    .res_upd (res_upd),
    .q       (psw)
  );

  assign flag_n = psw[POS_N];
  assign flag_v = psw[POS_V];
  assign flag_b = psw[POS_B];
  assign flag_h = psw[POS_H];
  assign flag_i = psw[POS_I];
  assign flag_z = psw[POS_Z];
  assign flag_c = psw[POS_C];

endmodule

// File: rtl/stat_flag_unit_chk.sv
module stat_flag_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          res_valid,
  input logic [1:0]    res_class,
  input logic [DW-1:0] res_data,
  input logic          res_carry,
  input logic          res_half,
  input logic          res_ovf,
  input logic          cmd_ei,
  input logic          cmd_di,
  input logic          cmd_clrv,
  input logic          cmd_bit,
  input logic [DW-1:0] bit_mem,
  input logic          cmd_brk,
  input logic          irq_ack,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic [7:0]    psw,
  input logic          flag_n,
  input logic          flag_v,
  input logic          flag_b,
  input logic          flag_h,
  input logic          flag_i,
  input logic          flag_z,
  input logic          flag_c
);

  // R2
  a_r2_reset_zero: assert property (@(posedge clk) rst |=> psw == 8'h00);

  // R9
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> psw == ($past(wr_data) & 8'hDF));

  // R3
  a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !wr_en) |=> flag_z == ($past(res_data) == '0));

  // R3
  a_r3_sign_flag: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !wr_en && !cmd_bit) |=> flag_n == $past(res_data[DW-1]));

  // R4
  a_r4_arith_carry: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'b01 && !wr_en) |=> flag_c == $past(res_carry));

  // R4
  a_r4_arith_ovf: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'b01 && !wr_en && !cmd_clrv && !cmd_bit)
    |=> flag_v == $past(res_ovf) && flag_h == $past(res_half));

  // R5
  a_r5_clear_pair: assert property (@(posedge clk) disable iff (rst)
    (cmd_clrv && !wr_en) |=> !flag_v && !flag_h);

  // R6
  a_r6_bit_copy: assert property (@(posedge clk) disable iff (rst)
    (cmd_bit && !wr_en && !cmd_clrv)
    |=> flag_n == $past(bit_mem[DW-1]) && flag_v == $past(bit_mem[DW-2]));

  // R7
  a_r7_break_sets: assert property (@(posedge clk) disable iff (rst)
    (cmd_brk && !wr_en) |=> flag_b);

  // R8
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((irq_ack || cmd_di) && !wr_en) |=> !flag_i);

  // R8
  a_r8_enable_sets: assert property (@(posedge clk) disable iff (rst)
    (cmd_ei && !cmd_di && !irq_ack && !wr_en) |=> flag_i);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !res_valid && !cmd_ei && !cmd_di && !cmd_clrv && !cmd_bit
     && !cmd_brk && !irq_ack) |=> $stable(psw));

endmodule

bind stat_flag_unit stat_flag_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_stat_flag_unit.sv
`timescale 1ns/1ps
module test_stat_flag_unit;

  logic       clk = 1'b0;
  logic       rst;
  logic       res_valid, res_carry, res_half, res_ovf;
  logic [1:0] res_class;
  logic [7:0] res_data, bit_mem, wr_data, psw;
  logic       cmd_ei, cmd_di, cmd_clrv, cmd_bit, cmd_brk, irq_ack, wr_en;
  logic       flag_n, flag_v, flag_b, flag_h, flag_i, flag_z, flag_c;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  stat_flag_unit i_stat_flag_unit (.*);

  task automatic idle();
    res_valid = 0; res_class = 2'b00; res_data = 8'h00;
    res_carry = 0; res_half = 0; res_ovf = 0;
    cmd_ei = 0; cmd_di = 0; cmd_clrv = 0; cmd_bit = 0; bit_mem = 8'h00;
    cmd_brk = 0; irq_ack = 0; wr_en = 0; wr_data = 8'h00;
  endtask

  // Let one edge capture the driven inputs, then return inputs to idle.
  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] flags;
    flags = {flag_n, flag_v, 1'b0, flag_b, flag_h, flag_i, flag_z, flag_c};
    n_chk++;
    if (psw !== exp || flags !== exp) begin
      n_bad++;
      $display("FAIL %s: psw=%02h flags=%02h expected=%02h", req, psw, flags, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v; tick();
  endtask

  task automatic alu(input logic [1:0] cls, input logic [7:0] d,
                     input logic c, input logic h, input logic v);
    res_valid = 1; res_class = cls; res_data = d;
    res_carry = c; res_half = h; res_ovf = v;
  endtask

  task automatic t_reset();
    chk("R2 reset value", 8'h00);
  endtask

  task automatic t_write();
    load(8'hFF);
    chk("R1 R9 spare bit stays low on full write", 8'hDF);
    @(negedge clk);
    wr_en = 1; wr_data = 8'h00; cmd_ei = 1; cmd_brk = 1; cmd_bit = 1; bit_mem = 8'hC0;
    alu(2'b01, 8'h80, 1, 1, 1);
    tick();
    chk("R9 write overrides all strobes", 8'h00);
  endtask

  task automatic t_move();
    load(8'h00);
    @(negedge clk); alu(2'b00, 8'h00, 1, 1, 1); tick();
    chk("R3 zero result sets Z, move ignores C V H", 8'h02);
    @(negedge clk); alu(2'b00, 8'h80, 0, 0, 0); tick();
    chk("R3 sign from bit 7", 8'h80);
    load(8'h49);
    @(negedge clk); alu(2'b00, 8'h05, 0, 0, 0); tick();
    chk("R4 move keeps C V H", 8'h49);
    load(8'h00);
    @(negedge clk); alu(2'b11, 8'h00, 1, 1, 1); tick();
    chk("R4 class 3 acts as move", 8'h02);
  endtask

  task automatic t_arith();
    load(8'h00);
    @(negedge clk); alu(2'b01, 8'h00, 1, 1, 1); tick();
    chk("R4 arithmetic loads C V H", 8'h4B);
    @(negedge clk); alu(2'b01, 8'h7F, 0, 0, 0); tick();
    chk("R4 arithmetic clears C V H", 8'h00);
  endtask

  task automatic t_shift();
    load(8'h48);
    @(negedge clk); alu(2'b10, 8'h81, 1, 0, 0); tick();
    chk("R4 shift loads C keeps V H", 8'hC9);
    @(negedge clk); alu(2'b10, 8'h40, 0, 1, 1); tick();
    chk("R4 shift clears C keeps V H", 8'h48);
  endtask

  task automatic t_clrv();
    load(8'hFF);
    @(negedge clk); cmd_clrv = 1; tick();
    chk("R5 clear drops V and H only", 8'h97);
    load(8'h00);
    @(negedge clk); cmd_clrv = 1; alu(2'b01, 8'h01, 0, 1, 1); tick();
    chk("R5 clear beats arithmetic V H", 8'h00);
    load(8'h08);
    @(negedge clk); cmd_ei = 1; cmd_brk = 1; cmd_bit = 1; bit_mem = 8'h00; tick();
    chk("R5 other strobes leave H", 8'h1C);
  endtask

  task automatic t_bit();
    load(8'h00);
    @(negedge clk); cmd_bit = 1; bit_mem = 8'hC0; alu(2'b00, 8'h00, 0, 0, 0); tick();
    chk("R6 bit copies 7 and 6, Z from result", 8'hC2);
    @(negedge clk); cmd_bit = 1; bit_mem = 8'h00; alu(2'b01, 8'h80, 1, 1, 1); tick();
    chk("R6 bit beats result N V, C H follow result", 8'h09);
    @(negedge clk); cmd_bit = 1; bit_mem = 8'h40; cmd_clrv = 1; tick();
    chk("R6 clear beats bit-test V", 8'h01);
  endtask

  task automatic t_brk();
    load(8'h00);
    @(negedge clk); cmd_brk = 1; tick();
    chk("R7 break sets B", 8'h10);
    @(negedge clk); cmd_di = 1; irq_ack = 1; cmd_clrv = 1; alu(2'b01, 8'h01, 0, 0, 0); tick();
    chk("R7 B survives other strobes", 8'h10);
  endtask

  task automatic t_int();
    load(8'h00);
    @(negedge clk); cmd_ei = 1; tick();
    chk("R8 enable sets I", 8'h04);
    @(negedge clk); irq_ack = 1; tick();
    chk("R8 acceptance clears I", 8'h00);
    @(negedge clk); cmd_ei = 1; irq_ack = 1; tick();
    chk("R8 acceptance beats enable", 8'h00);
    @(negedge clk); cmd_ei = 1; tick();
    @(negedge clk); cmd_ei = 1; cmd_di = 1; tick();
    chk("R8 disable beats enable", 8'h00);
  endtask

  task automatic t_hold();
    load(8'hA5);
    chk("R9 write value", 8'h85);
    @(negedge clk);
    res_class = 2'b01; res_data = 8'h00; res_carry = 0; res_half = 1; res_ovf = 1;
    bit_mem = 8'hFF; wr_data = 8'h00;
    tick();
    chk("R10 data without strobes ignored", 8'h85);
    repeat (3) tick();
    chk("R10 holds over idle cycles", 8'h85);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_write();
    t_move();
    t_arith();
    t_shift();
    t_clrv();
    t_bit();
    t_brk();
    t_int();
    t_hold();
    @(negedge clk); rst = 1; wr_en = 1; wr_data = 8'hFF; tick(); rst = 0;
    chk("R2 reset beats write", 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule